// File: doc/BRIEF.md
# Video Receiver Lock Detect Controller

This block supervises the lock sequence of a dual-rate serial video receiver. The analogue reclocker, the serial-to-parallel converter and the sync-word detectors stay outside it. They report to it through a carrier-loss flag, a PLL-lock flag and two sync-found flags, one for SMPTE TRS words and one for DVB-ASI words. In return the block drives the reclocker's rate choice (SD at 270 Mb/s or HD at 1.485 Gb/s) and a request to park the VCO at the centre of its pull range. It also drives the LOCKED indication, a mute and a force-to-zero control for the parallel data path, and status copies of the SMPTE-bypass and DVB-ASI mode pins.

In master mode, once a carrier is present, the controller hunts for sync words. It makes four attempts and flips the rate at each attempt boundary. If all four fail, it falls back to an unassisted PLL-only wait. In slave mode a pin fixes the rate, so every attempt runs at that single rate. The PLL-only fallback ends differently in the two modes. A slave passes the data through and may report lock. A master keeps LOCKED low and forces the data path and status outputs to zero. A loss of carrier at any time sends the controller back to its invalid-input state. The attempt length and the PLL-only timeout are parameters counted in clock cycles.

Top module: `vlock_supervisor`

## Requirements
- R1: While `carrier_lost` is high, `locked` is low in the same cycle. From the next clock edge on, `centre_req` is high, and `par_mute` is high (except as in R2). While `par_mute` is high, `bypass_stat` and `asi_stat` are low.
- R2: In slave mode (`master_sel`=0) with `asi_mode_in`=1, `par_mute` stays low during carrier loss. `locked` still stays low.
- R3: In master mode the hunt starts at SD (`rate_hd`=0) on the first edge after the invalid-input state is left, and `centre_req` goes low. Each attempt lasts ATTEMPT_CYCLES cycles, and `rate_hd` toggles at each attempt boundary.
- R4: In slave mode `rate_hd` equals `slave_rate_hd` in every cycle, and it never toggles during attempts.
- R5: In the hunt, lock needs `pll_lock`=1 together with `trs_found` or `asi_found`. The block enters the locked state on the next edge. `locked` is then high while these conditions hold, and `rate_hd` stays frozen.
- R6: After NUM_ATTEMPTS (4) attempts without lock, the controller enters PLL-only mode. There `rate_hd` stops toggling, `centre_req` and `locked` are low, and it waits up to PLL_ONLY_CYCLES cycles for `pll_lock`.
- R7: When the PLL-only wait times out, the hunt restarts from attempt one at SD on the next edge.
- R8: In master mode, a `pll_lock` seen in PLL-only mode leads to the PLL-only-locked state. There `locked` is low, `par_force_low` is high, and `bypass_stat` and `asi_stat` are low. Loss of `pll_lock` returns to the hunt at SD.
- R9: In slave mode, a `pll_lock` seen in PLL-only mode leads to pass-through with `par_force_low`=0. `locked` is high only while `pll_lock`=1, `bypass_mode_in`=0 and `asi_mode_in`=0. In this state `bypass_stat` and `asi_stat` copy their pins.
- R10: While locked, loss of `pll_lock` or of both sync flags drops `locked` in the same cycle. On the next edge the controller returns to attempt one of the hunt (SD in master mode).
- R11: During reset the controller is in the invalid-input state: `centre_req`=1, `locked`=0, `rate_hd`=0, and in master mode `par_mute`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| carrier_lost | input | 1 | High when no valid serial signal is present |
| pll_lock | input | 1 | Reclocker PLL has locked |
| trs_found | input | 1 | SMPTE TRS sync words identified |
| asi_found | input | 1 | DVB-ASI sync words identified |
| master_sel | input | 1 | 1 = master (hunting) mode, 0 = slave mode |
| slave_rate_hd | input | 1 | Slave-mode rate: 1 = HD, 0 = SD |
| bypass_mode_in | input | 1 | SMPTE-bypass mode pin |
| asi_mode_in | input | 1 | DVB-ASI mode pin |
| rate_hd | output | 1 | Reclocker rate select: 1 = 1.485 Gb/s, 0 = 270 Mb/s |
| centre_req | output | 1 | Park the VCO at the centre of its pull range |
| locked | output | 1 | Lock indication |
| par_mute | output | 1 | Mute the parallel outputs |
| par_force_low | output | 1 | Force the parallel outputs to all zeros |
| bypass_stat | output | 1 | SMPTE-bypass status output |
| asi_stat | output | 1 | DVB-ASI status output |

## Verification
The assertions check several rules on every cycle. Carrier loss blocks LOCKED at once and raises the centre request one edge later. The slave rate always follows its pin. LOCKED never stands without PLL lock. A forced-low data path never coexists with LOCKED or a live status bit. An attempt boundary in master mode flips the rate, and an exhausted hunt lands in PLL-only mode. Other behaviour needs the bench's scenarios. These cover the exact attempt and timeout lengths and the restart at SD after a timeout or a lost lock. They also cover the freeze of the rate while locked and the slave pass-through whose LOCKED depends on the mode pins. Each of these depends on a chosen history of inputs across many cycles.

// File: rtl/vlock_pkg.sv
package vlock_pkg;

  typedef enum logic [2:0] {
    ST_NOSIG   = 3'd0,
    ST_HUNT    = 3'd1,
    ST_LOCKED  = 3'd2,
    ST_PLLONLY = 3'd3,
    ST_PLLLOCK = 3'd4
  } vl_state_e;

  function automatic logic sync_seen(input logic trs, input logic asi);
    return trs | asi;
  endfunction

  function automatic logic mute_needed(input vl_state_e st, input logic master,
                                       input logic asi_pin);
    return (st == ST_NOSIG) && (master || !asi_pin);
  endfunction

  function automatic logic slave_pll_lock_ok(input logic master, input logic pll,
                                             input logic byp, input logic asi);
    return !master && pll && !byp && !asi;
  endfunction

endpackage

// File: rtl/vlock_timer.sv
module vlock_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] terminal,
  output logic          expired
);
  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (restart) count <= '0;
    else if (!expired) count <= count + 1'b1;
  end

  assign expired = (count == terminal);
endmodule

// File: rtl/vlock_attempts.sv
module vlock_attempts #(
  parameter int NUM_ATTEMPTS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic advance,
  output logic rate_hd,
  output logic last
);
  localparam int AW = $clog2(NUM_ATTEMPTS + 1);
  logic [AW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      rate_hd <= 1'b0;
    end else if (clear) begin
      idx     <= '0;
      rate_hd <= 1'b0;
    end else if (advance) begin
      idx     <= idx + 1'b1;
      rate_hd <= ~rate_hd;
    end
  end

  assign last = (idx == AW'(NUM_ATTEMPTS - 1));
endmodule

// File: rtl/vlock_outmap.sv
module vlock_outmap
  import vlock_pkg::*;
(
  input  vl_state_e st,
  input  logic      master_sel,
  input  logic      carrier_lost,
  input  logic      pll_lock,
  input  logic      sync_ok,
  input  logic      bypass_mode_in,
  input  logic      asi_mode_in,
  input  logic      att_rate_hd,
  input  logic      slave_rate_hd,
  output logic      rate_hd,
  output logic      centre_req,
  output logic      locked,
  output logic      par_mute,
  output logic      par_force_low,
  output logic      bypass_stat,
  output logic      asi_stat
);
  logic lock_sync, lock_pll_only;

  always_comb begin
    rate_hd       = master_sel ? att_rate_hd : slave_rate_hd;
    centre_req    = (st == ST_NOSIG);
    lock_sync     = (st == ST_LOCKED) && pll_lock && sync_ok;
    lock_pll_only = (st == ST_PLLLOCK) &&
                    slave_pll_lock_ok(master_sel, pll_lock, bypass_mode_in, asi_mode_in);
    locked        = !carrier_lost && (lock_sync || lock_pll_only);
    par_mute      = mute_needed(st, master_sel, asi_mode_in);
    par_force_low = (st == ST_PLLLOCK) && master_sel;
    bypass_stat   = bypass_mode_in && !par_mute && !par_force_low;
    asi_stat      = asi_mode_in && !par_mute && !par_force_low;
  end
endmodule

// File: rtl/vlock_supervisor.sv
module vlock_supervisor
  import vlock_pkg::*;
#(
  parameter int ATTEMPT_CYCLES  = 1024,
  parameter int PLL_ONLY_CYCLES = 1485000,
  parameter int NUM_ATTEMPTS    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_lost,
  input  logic pll_lock,
  input  logic trs_found,
  input  logic asi_found,
  input  logic master_sel,
  input  logic slave_rate_hd,
  input  logic bypass_mode_in,
  input  logic asi_mode_in,
  output logic rate_hd,
  output logic centre_req,
  output logic locked,
  output logic par_mute,
  output logic par_force_low,
  output logic bypass_stat,
  output logic asi_stat
);
  localparam int MAXC = (ATTEMPT_CYCLES > PLL_ONLY_CYCLES) ? ATTEMPT_CYCLES : PLL_ONLY_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  vl_state_e     st, nxt;
  logic          sync_ok, tmr_expired, tmr_restart;
  logic          att_clear, att_advance, att_rate_hd, att_last;
  logic [CW-1:0] tmr_terminal;

  // named events for the checker
  logic hunt_attempt_end, hunt_exhausted, in_pll_only;

  assign sync_ok          = pll_lock && sync_seen(trs_found, asi_found);
  assign hunt_attempt_end = (st == ST_HUNT) && tmr_expired && !sync_ok;
  assign hunt_exhausted   = hunt_attempt_end && att_last;
  assign in_pll_only      = (st == ST_PLLONLY);

  always_comb begin
    nxt = st;
    if (carrier_lost) nxt = ST_NOSIG;
    else begin
      case (st)
        ST_NOSIG:   nxt = ST_HUNT;
        ST_HUNT: begin
          if (sync_ok)             nxt = ST_LOCKED;
          else if (hunt_exhausted) nxt = ST_PLLONLY;
        end
        ST_LOCKED:  if (!sync_ok)  nxt = ST_HUNT;
        ST_PLLONLY: begin
          if (pll_lock)            nxt = ST_PLLLOCK;
          else if (tmr_expired)    nxt = ST_HUNT;
        end
        ST_PLLLOCK: if (!pll_lock) nxt = ST_HUNT;
        default:                   nxt = ST_NOSIG;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_NOSIG;
    else        st <= nxt;
  end

  assign att_advance  = hunt_attempt_end && !att_last && !carrier_lost;
  assign att_clear    = (st == ST_NOSIG) || ((st != ST_HUNT) && (nxt == ST_HUNT));
  assign tmr_restart  = (nxt != st) || att_advance;
  assign tmr_terminal = (st == ST_PLLONLY) ? CW'(PLL_ONLY_CYCLES - 1) : CW'(ATTEMPT_CYCLES - 1);

  vlock_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(tmr_restart),
    .terminal(tmr_terminal), .expired(tmr_expired)
  );

  vlock_attempts #(.NUM_ATTEMPTS(NUM_ATTEMPTS)) u_attempts (
    .clk(clk), .rst_n(rst_n), .clear(att_clear), .advance(att_advance),
    .rate_hd(att_rate_hd), .last(att_last)
  );

  vlock_outmap u_outmap (
    .st(st), .master_sel(master_sel), .carrier_lost(carrier_lost),
    .pll_lock(pll_lock), .sync_ok(sync_ok), .bypass_mode_in(bypass_mode_in),
    .asi_mode_in(asi_mode_in), .att_rate_hd(att_rate_hd),
    .slave_rate_hd(slave_rate_hd), .rate_hd(rate_hd), .centre_req(centre_req),
    .locked(locked), .par_mute(par_mute), .par_force_low(par_force_low),
    .bypass_stat(bypass_stat), .asi_stat(asi_stat)
  );
endmodule

// File: rtl/vlock_supervisor_chk.sv
module vlock_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic carrier_lost,
  input logic pll_lock,
  input logic trs_found,
  input logic asi_found,
  input logic master_sel,
  input logic slave_rate_hd,
  input logic bypass_mode_in,
  input logic asi_mode_in,
  input logic rate_hd,
  input logic centre_req,
  input logic locked,
  input logic par_mute,
  input logic par_force_low,
  input logic bypass_stat,
  input logic asi_stat,
  input logic hunt_attempt_end,
  input logic hunt_exhausted,
  input logic in_pll_only
);
  p_centre_after_loss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_lost |=> centre_req);

  p_unlocked_on_loss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_lost |-> !locked);

  p_slave_asi_unmuted_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_sel && asi_mode_in) |-> !par_mute);

  p_rate_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hunt_attempt_end && !hunt_exhausted && master_sel && !carrier_lost)
      |=> (!master_sel || rate_hd != $past(rate_hd)));

  p_slave_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !master_sel |-> (rate_hd == slave_rate_hd));

  p_lock_needs_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && master_sel) |-> (pll_lock && (trs_found || asi_found)));

  p_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hunt_exhausted && !carrier_lost) |=> in_pll_only);

  p_force_low_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    par_force_low |-> (!locked && !bypass_stat && !asi_stat));

  p_slave_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !master_sel && !(trs_found || asi_found))
      |-> (!bypass_mode_in && !asi_mode_in));

  p_lock_needs_pll_r10: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> pll_lock);
endmodule

bind vlock_supervisor vlock_supervisor_chk u_chk (.*);

// File: tb/vlock_supervisor_test.sv
module vlock_supervisor_test;
  localparam int CLK_PERIOD = 10;
  localparam int A = 8;
  localparam int P = 20;

  logic clk = 1'b0;
  logic rst_n, carrier_lost, pll_lock, trs_found, asi_found;
  logic master_sel, slave_rate_hd, bypass_mode_in, asi_mode_in;
  logic rate_hd, centre_req, locked, par_mute, par_force_low, bypass_stat, asi_stat;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlock_supervisor #(.ATTEMPT_CYCLES(A), .PLL_ONLY_CYCLES(P), .NUM_ATTEMPTS(4)) uut (
    .clk(clk), .rst_n(rst_n), .carrier_lost(carrier_lost), .pll_lock(pll_lock),
    .trs_found(trs_found), .asi_found(asi_found), .master_sel(master_sel),
    .slave_rate_hd(slave_rate_hd), .bypass_mode_in(bypass_mode_in),
    .asi_mode_in(asi_mode_in), .rate_hd(rate_hd), .centre_req(centre_req),
    .locked(locked), .par_mute(par_mute), .par_force_low(par_force_low),
    .bypass_stat(bypass_stat), .asi_stat(asi_stat)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic master, input logic srate);
    rst_n = 1'b0; carrier_lost = 1'b0; pll_lock = 1'b0; trs_found = 1'b0;
    asi_found = 1'b0; master_sel = master; slave_rate_hd = srate;
    bypass_mode_in = 1'b0; asi_mode_in = 1'b0;
    tick(3);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state;
    do_reset(1'b1, 1'b0);
    rst_n = 1'b0;
    tick(2);
    chk("R11", "centre_req", centre_req, 1'b1);
    chk("R11", "locked", locked, 1'b0);
    chk("R11", "rate_hd", rate_hd, 1'b0);
    chk("R11", "par_mute", par_mute, 1'b1);
    rst_n = 1'b1;
  endtask

  task automatic t_master_hunt;
    do_reset(1'b1, 1'b0);
    tick(1);
    chk("R3", "centre_req low in hunt", centre_req, 1'b0);
    chk("R3", "first attempt SD", rate_hd, 1'b0);
    tick(A - 1);
    chk("R3", "attempt one still SD", rate_hd, 1'b0);
    tick(1);
    chk("R3", "attempt two HD", rate_hd, 1'b1);
    tick(A);
    chk("R3", "attempt three SD", rate_hd, 1'b0);
    tick(A);
    chk("R3", "attempt four HD", rate_hd, 1'b1);
    tick(A);
    chk("R6", "pll-only rate frozen", rate_hd, 1'b1);
    chk("R6", "pll-only centre_req", centre_req, 1'b0);
    chk("R6", "pll-only locked", locked, 1'b0);
    tick(P - 1);
    chk("R6", "pll-only wait full length", rate_hd, 1'b1);
    tick(1);
    chk("R7", "restart at SD", rate_hd, 1'b0);
    tick(A);
    chk("R7", "restarted hunt toggles", rate_hd, 1'b1);
  endtask

  task automatic t_master_lock;
    do_reset(1'b1, 1'b0);
    tick(1 + A);
    chk("R5", "second attempt HD", rate_hd, 1'b1);
    pll_lock = 1'b1;
    tick(2);
    chk("R5", "pll alone no lock", locked, 1'b0);
    asi_found = 1'b1;
    #1;
    chk("R5", "lock waits for edge", locked, 1'b0);
    tick(1);
    chk("R5", "locked on asi sync", locked, 1'b1);
    tick(A + 2);
    chk("R5", "lock holds", locked, 1'b1);
    chk("R5", "rate frozen while locked", rate_hd, 1'b1);
    asi_found = 1'b0;
    #1;
    chk("R10", "sync loss drops locked", locked, 1'b0);
    tick(1);
    chk("R10", "relock hunt at SD", rate_hd, 1'b0);
    chk("R10", "back in hunt not centre", centre_req, 1'b0);
    tick(A);
    chk("R10", "hunt running again", rate_hd, 1'b1);
    trs_found = 1'b1;
    tick(1);
    chk("R5", "locked on trs sync", locked, 1'b1);
    pll_lock = 1'b0;
    #1;
    chk("R10", "pll loss drops locked", locked, 1'b0);
    trs_found = 1'b0;
  endtask

  task automatic t_carrier_loss;
    do_reset(1'b1, 1'b0);
    bypass_mode_in = 1'b1; asi_mode_in = 1'b1;
    tick(1);
    chk("R1", "bypass_stat live in hunt", bypass_stat, 1'b1);
    pll_lock = 1'b1; trs_found = 1'b1;
    tick(1);
    chk("R5", "locked before loss", locked, 1'b1);
    carrier_lost = 1'b1;
    #1;
    chk("R1", "locked drops at once", locked, 1'b0);
    tick(1);
    chk("R1", "centre_req", centre_req, 1'b1);
    chk("R1", "par_mute", par_mute, 1'b1);
    chk("R1", "bypass_stat muted", bypass_stat, 1'b0);
    chk("R1", "asi_stat muted", asi_stat, 1'b0);
    carrier_lost = 1'b0;
    tick(1);
    chk("R3", "hunt after carrier returns", centre_req, 1'b0);
    chk("R3", "hunt restarts SD", rate_hd, 1'b0);
    chk("R5", "no lock until next edge", locked, 1'b0);
    tick(1);
    chk("R5", "relock", locked, 1'b1);
  endtask

  task automatic t_slave_asi;
    do_reset(1'b0, 1'b0);
    carrier_lost = 1'b1; asi_mode_in = 1'b1;
    tick(2);
    chk("R2", "asi slave unmuted", par_mute, 1'b0);
    chk("R2", "centre_req still high", centre_req, 1'b1);
    chk("R2", "locked low", locked, 1'b0);
    asi_mode_in = 1'b0;
    #1;
    chk("R1", "slave non-asi muted", par_mute, 1'b1);
    carrier_lost = 1'b0;
  endtask

  task automatic t_slave_rate;
    do_reset(1'b0, 1'b1);
    #1;
    chk("R4", "slave rate HD", rate_hd, 1'b1);
    tick(1 + A);
    chk("R4", "no toggle at boundary", rate_hd, 1'b1);
    slave_rate_hd = 1'b0;
    #1;
    chk("R4", "slave rate SD", rate_hd, 1'b0);
    tick(A);
    chk("R4", "SD held", rate_hd, 1'b0);
  endtask

  task automatic t_master_pllonly;
    do_reset(1'b1, 1'b0);
    tick(4 * A + 1);
    pll_lock = 1'b1; bypass_mode_in = 1'b1; asi_mode_in = 1'b1;
    tick(1);
    chk("R8", "force low", par_force_low, 1'b1);
    chk("R8", "locked low", locked, 1'b0);
    chk("R8", "bypass_stat low", bypass_stat, 1'b0);
    chk("R8", "asi_stat low", asi_stat, 1'b0);
    pll_lock = 1'b0;
    tick(1);
    chk("R8", "force released", par_force_low, 1'b0);
    chk("R8", "hunt at SD", rate_hd, 1'b0);
  endtask

  task automatic t_slave_pllonly;
    do_reset(1'b0, 1'b0);
    tick(4 * A + 1);
    pll_lock = 1'b1;
    tick(1);
    chk("R9", "slave pll-only locked", locked, 1'b1);
    chk("R9", "no force low", par_force_low, 1'b0);
    bypass_mode_in = 1'b1;
    #1;
    chk("R9", "bypass pin blocks lock", locked, 1'b0);
    chk("R9", "bypass_stat follows pin", bypass_stat, 1'b1);
    bypass_mode_in = 1'b0; asi_mode_in = 1'b1;
    #1;
    chk("R9", "asi pin blocks lock", locked, 1'b0);
    asi_mode_in = 1'b0;
    #1;
    chk("R9", "lock returns", locked, 1'b1);
    pll_lock = 1'b0;
    #1;
    chk("R9", "pll loss drops lock", locked, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_master_hunt();
    t_master_lock();
    t_carrier_loss();
    t_slave_asi();
    t_slave_rate();
    t_master_pllonly();
    t_slave_pllonly();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule